// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a byte-organized non-volatile memory that answers on a shared two-wire bus (clock line and data line). It runs on a fast system clock, oversamples both lines through synchronizers, and pulls the data line low through an open-drain enable (`sda_pull`). The bus master addresses the device with a select byte whose low address bits come from two strap inputs, so four devices can share one bus. It then sends a two-byte word address and either writes data bytes or turns the bus around to read.

Writes land in a page buffer first. Only a STOP on a byte boundary commits them to the storage array, and a self-timed programming window follows. During that window the device ignores its select byte, so the master can poll for completion. A write-lock input suppresses programming, but the bus transfer itself still completes normally. Reads come straight from the array and walk the address pointer across the whole space.

The controller is one state machine. Its states are `ST_IDLE`, `ST_DEVSEL`, `ST_ACK_SEL`, `ST_ADDR_HI`, `ST_ACK_HI`, `ST_ADDR_LO`, `ST_ACK_LO`, `ST_WDATA`, `ST_ACK_WD`, `ST_RDATA` and `ST_MACK`. Apart from the START and STOP overrides, every transition happens on a falling clock line:
- START in any state goes to `ST_DEVSEL`.
- STOP in any state goes to `ST_IDLE`.
- `ST_DEVSEL` goes to `ST_ACK_SEL` on a match and to `ST_IDLE` on a miss or while busy.
- `ST_ACK_SEL` goes to `ST_RDATA` for a read and to `ST_ADDR_HI` for a write.
- The address path runs `ST_ADDR_HI` → `ST_ACK_HI` → `ST_ADDR_LO` → `ST_ACK_LO` → `ST_WDATA`.
- Writes loop `ST_WDATA` ↔ `ST_ACK_WD`.
- Reads go `ST_RDATA` → `ST_MACK`. From `ST_MACK`, a master acknowledge returns to `ST_RDATA` and a master no-acknowledge goes to `ST_IDLE`.

`ADDR_W` sets the address width; full-size parts use 15 or 14. `PAGE_W` sets the page (6 gives 64 bytes). `PROG_CYCLES` is the programming time in system clocks and must be at least 2**`PAGE_W`.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START (data falling while clock high) in any state, including mid-byte, abandons the transfer and expects a select byte. A STOP (data rising while clock high) returns the device to idle.
- R2: The select byte is sent MSB first as 1010, then 0, then strap bit 1, strap bit 0, then the read/write bit (1 = read). The device acknowledges it, by holding data low through the ninth clock, only on a match. Otherwise it leaves the line released until the next START.
- R3: A write select is followed by two word-address bytes, high byte first, each acknowledged. Only the low `ADDR_W` bits of the 16 are used.
- R4: Each data byte is acknowledged and stored at the pointer. The low `PAGE_W` pointer bits then advance and wrap inside the page while the upper bits hold, so excess bytes overwrite earlier ones in the same page.
- R5: A write of fewer bytes than a page changes only the locations that were sent.
- R6: Programming happens only on a STOP that arrives on a byte boundary after at least one data byte. A START or a mid-byte STOP during a write programs nothing and starts no busy window.
- R7: After a programmed write, the device ignores and does not acknowledge its select byte for `PROG_CYCLES` system clocks, then responds again.
- R8: While `write_lock` is high at the STOP, nothing is programmed and no busy window starts. Every byte of the transfer is still acknowledged.
- R9: A random read (write select, two address bytes, repeated START, read select) returns the byte at that address.
- R10: The pointer advances by one over the full address range after each byte sent and rolls over from the last location to zero. A master acknowledge is followed by the next byte, and a master no-acknowledge ends the read.
- R11: A current-address read (read select without an address) returns the byte at the pointer, which is one past the last byte read.
- R12: After reset the device is idle and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain enable) |
| strap_addr | input | 2 | Strap pins; bit 1 and bit 0 of the device address |
| write_lock | input | 1 | High blocks all programming |

## Verification
The bench builds the block with `ADDR_W` = 6, `PAGE_W` = 3 and `PROG_CYCLES` = 1000. With a 64-byte array and 8-byte pages, the bench can prefill the whole array, read all of it back and reach the rollover from the last location to zero within a few reads. A page wrap needs only ten data bytes. An address high byte of 0xFF then shows that the bits above `ADDR_W` are discarded. The busy window outlasts the first poll but expires after a few polls, so both the silent and the answering sides of completion polling are observed.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ACK_SEL,
        ST_ADDR_HI,
        ST_ACK_HI,
        ST_ADDR_LO,
        ST_ACK_LO,
        ST_WDATA,
        ST_ACK_WD,
        ST_RDATA,
        ST_MACK
    } eep_state_t;

    localparam logic [3:0] DEV_FAMILY = 4'b1010;

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic scl_d;
    logic sda_d;
    logic scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_in};
            scl_d  <= scl_ff[SYNC_STAGES-1];
            sda_d  <= sda_ff[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_ff[SYNC_STAGES-1];
    assign sda_s     = sda_ff[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int PROG_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(PROG_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/eep_page_store.sv
module eep_page_store #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [PAGE_W-1:0]        wr_off,
    input  logic [7:0]               wr_data,
    input  logic                     commit_go,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page,
    input  logic                     lock,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     has_data
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int MEM_BYTES  = 1 << ADDR_W;
    localparam int PSEL_W     = ADDR_W - PAGE_W;

    logic [7:0]            mem  [MEM_BYTES];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask;
    logic                  walking;
    logic [PAGE_W-1:0]     idx;
    logic [PSEL_W-1:0]     page_q;
    logic                  mem_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask    <= '0;
            walking <= 1'b0;
            idx     <= '0;
            page_q  <= '0;
        end else begin
            if (clr) begin
                mask <= '0;
            end else if (wr_en) begin
                mask[wr_off] <= 1'b1;
            end
            if (commit_go) begin
                walking <= 1'b1;
                idx     <= '0;
                page_q  <= commit_page;
            end else if (walking) begin
                idx <= idx + PAGE_W'(1);
                if (idx == PAGE_W'(PAGE_BYTES - 1)) begin
                    walking <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            pbuf[wr_off] <= wr_data;
        end
    end

    assign mem_we = walking && mask[idx] && !lock;

    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem[{page_q, idx}] <= pbuf[idx];
        end
    end

    assign rd_data  = mem[rd_addr];
    assign has_data = |mask;

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import eeprom_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 6,
    parameter int PROG_CYCLES = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    input  logic [1:0] strap_addr,
    input  logic       write_lock
);
    localparam int PSEL_W = ADDR_W - PAGE_W;

    eep_state_t state, state_nx;

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [2:0]        bitcnt;
    logic              bit_live;
    logic [7:0]        shreg;
    logic [7:0]        tx;
    logic [7:0]        addr_hi;
    logic [ADDR_W-1:0] ptr;
    logic              rw_q;
    logic              mack_ok;
    logic              sda_pull_q;
    logic              busy;
    logic              has_data;
    logic [7:0]        rd_data;
    logic              rx_state;
    logic              byte_done;
    logic              sel_hit;
    logic              buf_clr;
    logic              buf_we;
    logic              commit_go;

    eep_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit_go),
        .busy  (busy)
    );

    eep_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (buf_clr),
        .wr_en       (buf_we),
        .wr_off      (ptr[PAGE_W-1:0]),
        .wr_data     (shreg),
        .commit_go   (commit_go),
        .commit_page (ptr[ADDR_W-1:PAGE_W]),
        .lock        (write_lock),
        .rd_addr     (ptr),
        .rd_data     (rd_data),
        .has_data    (has_data)
    );

    assign rx_state  = (state == ST_DEVSEL) || (state == ST_ADDR_HI) ||
                       (state == ST_ADDR_LO) || (state == ST_WDATA);
    assign byte_done = bit_live && (bitcnt == 3'd7);
    assign sel_hit   = (shreg[7:1] == {DEV_FAMILY, 1'b0, strap_addr}) && !busy;
    assign buf_clr   = scl_fall && (state == ST_DEVSEL) && byte_done && sel_hit && !shreg[0];
    assign buf_we    = scl_fall && (state == ST_WDATA) && byte_done;
    assign commit_go = stop_det && (state == ST_WDATA) && (bitcnt == 3'd0) &&
                       has_data && !write_lock;
    assign sda_pull  = sda_pull_q;

    // next-state decode
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_DEVSEL;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_DEVSEL:  if (byte_done) state_nx = sel_hit ? ST_ACK_SEL : ST_IDLE;
                ST_ACK_SEL: state_nx = rw_q ? ST_RDATA : ST_ADDR_HI;
                ST_ADDR_HI: if (byte_done) state_nx = ST_ACK_HI;
                ST_ACK_HI:  state_nx = ST_ADDR_LO;
                ST_ADDR_LO: if (byte_done) state_nx = ST_ACK_LO;
                ST_ACK_LO:  state_nx = ST_WDATA;
                ST_WDATA:   if (byte_done) state_nx = ST_ACK_WD;
                ST_ACK_WD:  state_nx = ST_WDATA;
                ST_RDATA:   if (bitcnt == 3'd7) state_nx = ST_MACK;
                ST_MACK:    state_nx = mack_ok ? ST_RDATA : ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // datapath and line driver
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt     <= '0;
            bit_live   <= 1'b0;
            shreg      <= '0;
            tx         <= '0;
            addr_hi    <= '0;
            ptr        <= '0;
            rw_q       <= 1'b0;
            mack_ok    <= 1'b0;
            sda_pull_q <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt     <= '0;
            bit_live   <= 1'b0;
            sda_pull_q <= 1'b0;
        end else begin
            if (scl_rise) begin
                bit_live <= 1'b1;
                if (rx_state) shreg <= {shreg[6:0], sda_s};
                if (state == ST_MACK) mack_ok <= ~sda_s;
            end
            if (scl_fall) begin
                bit_live <= 1'b0;
                case (state)
                    ST_DEVSEL, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: begin
                        if (bit_live) begin
                            if (bitcnt == 3'd7) begin
                                bitcnt     <= '0;
                                sda_pull_q <= (state != ST_DEVSEL) || sel_hit;
                                if (state == ST_DEVSEL) rw_q    <= shreg[0];
                                if (state == ST_ADDR_HI) addr_hi <= shreg;
                                if (state == ST_ADDR_LO) ptr     <= ADDR_W'({addr_hi, shreg});
                                if (state == ST_WDATA)
                                    ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
                            end else begin
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end
                    end
                    ST_ACK_SEL: begin
                        if (rw_q) begin
                            tx         <= rd_data;
                            sda_pull_q <= ~rd_data[7];
                        end else begin
                            sda_pull_q <= 1'b0;
                        end
                    end
                    ST_ACK_HI, ST_ACK_LO, ST_ACK_WD: sda_pull_q <= 1'b0;
                    ST_RDATA: begin
                        if (bitcnt == 3'd7) begin
                            bitcnt     <= '0;
                            ptr        <= ptr + ADDR_W'(1);
                            sda_pull_q <= 1'b0;
                        end else begin
                            bitcnt     <= bitcnt + 3'd1;
                            tx         <= {tx[6:0], 1'b0};
                            sda_pull_q <= ~tx[6];
                        end
                    end
                    ST_MACK: begin
                        if (mack_ok) begin
                            tx         <= rd_data;
                            sda_pull_q <= ~rd_data[7];
                        end else begin
                            sda_pull_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk
    import eeprom_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input eep_state_t state,
    input logic       busy,
    input logic       sda_pull,
    input logic       start_det,
    input logic [2:0] bitcnt,
    input logic       wp
);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull); // R12

    AST_START_TO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEVSEL)); // R1

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state != ST_ACK_SEL)); // R7

    AST_PROG_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(state) == ST_WDATA) && ($past(bitcnt) == 3'd0)); // R6

    AST_PROG_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp)); // R8

endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .busy      (busy),
    .sda_pull  (sda_pull),
    .start_det (start_det),
    .bitcnt    (bitcnt),
    .wp        (write_lock)
);

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] straps = 2'b10;
    logic       wp = 1'b0;
    logic       sda_pull;
    logic       sda_line;
    bit         done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] model [64];
    logic [7:0] rbuf  [64];
    logic [7:0] wbuf  [16];

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    i2c_eeprom_slave #(
        .ADDR_W(6), .PAGE_W(3), .PROG_CYCLES(1000), .SYNC_STAGES(2)
    ) u_i2c_eeprom_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (m_scl),
        .sda_in     (sda_line),
        .sda_pull   (sda_pull),
        .strap_addr (straps),
        .write_lock (wp)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic qwait;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; qwait;
        m_scl = 1'b1; qwait;
        m_sda = 1'b0; qwait;
        m_scl = 1'b0; qwait;
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; qwait;
        m_scl = 1'b1; qwait;
        m_sda = 1'b1; qwait;
        qwait;
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            m_sda = b[i]; qwait;
            m_scl = 1'b1; qwait; qwait;
            m_scl = 1'b0; qwait;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; qwait;
        m_scl = 1'b1; qwait;
        ack = !sda_line; qwait;
        m_scl = 1'b0; qwait;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait;
            m_scl = 1'b1; qwait;
            b[i] = sda_line; qwait;
            m_scl = 1'b0;
        end
        qwait;
        m_sda = !give_ack; qwait;
        m_scl = 1'b1; qwait; qwait;
        m_scl = 1'b0; qwait;
        m_sda = 1'b1;
    endtask

    task automatic write_tx(input logic [15:0] a, input int n, output bit all_ack);
        bit k;
        all_ack = 1'b1;
        bus_start;
        send_byte(8'hA4, k); all_ack &= k;
        send_byte(a[15:8], k); all_ack &= k;
        send_byte(a[7:0], k); all_ack &= k;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], k); all_ack &= k;
        end
        bus_stop;
    endtask

    task automatic wait_ready(output int polls);
        bit k;
        polls = 0;
        do begin
            polls++;
            bus_start;
            send_byte(8'hA4, k);
            bus_stop;
        end while (!k && polls < 30);
    endtask

    task automatic read_rand(input logic [15:0] a, input int n, output bit all_ack);
        bit k;
        all_ack = 1'b1;
        bus_start;
        send_byte(8'hA4, k); all_ack &= k;
        send_byte(a[15:8], k); all_ack &= k;
        send_byte(a[7:0], k); all_ack &= k;
        bus_start;
        send_byte(8'hA5, k); all_ack &= k;
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop;
    endtask

    // write n bytes of wbuf from address a into the model with page wrap (R4)
    task automatic model_put(input int a, input int n);
        for (int i = 0; i < n; i++) model[(a & 56) | ((a + i) & 7)] = wbuf[i];
    endtask

    task automatic t_reset;
        check("R12 line released after reset", sda_pull, 0);
    endtask

    task automatic t_prefill;
        bit ok;
        int polls;
        for (int p = 0; p < 8; p++) begin
            for (int i = 0; i < 8; i++) wbuf[i] = 8'((p * 37) + (i * 11) + 3);
            write_tx(16'(p * 8), 8, ok);
            model_put(p * 8, 8);
            check("R2 R3 R4 prefill bytes acknowledged", ok, 1);
            wait_ready(polls);
            check("R7 first poll during programming ignored", polls > 1, 1);
            check("R7 device answers again after window", polls < 30, 1);
        end
        read_rand(16'h0000, 64, ok);
        check("R9 random read select acknowledged", ok, 1);
        for (int i = 0; i < 64; i++) check("R10 full sequential readback", rbuf[i], model[i]);
    endtask

    task automatic t_page_wrap;
        bit ok;
        int polls;
        for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'hC0 + i);
        write_tx(16'h0016, 10, ok);
        model_put(16'h16, 10);
        check("R4 page write acknowledged", ok, 1);
        wait_ready(polls);
        read_rand(16'h0010, 8, ok);
        for (int i = 0; i < 8; i++) check("R4 page wrap overwrite", rbuf[i], model[16 + i]);
    endtask

    task automatic t_partial;
        bit ok;
        int polls;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        write_tx(16'h0023, 2, ok);
        model_put(16'h23, 2);
        wait_ready(polls);
        read_rand(16'h0020, 8, ok);
        for (int i = 0; i < 8; i++) check("R5 partial page leaves others", rbuf[i], model[32 + i]);
    endtask

    task automatic t_lock;
        bit ok;
        int polls;
        wp = 1'b1;
        wbuf[0] = 8'h3C;
        write_tx(16'h0005, 1, ok);
        check("R8 locked write still acknowledged", ok, 1);
        wait_ready(polls);
        check("R8 no busy window when locked", polls, 1);
        wp = 1'b0;
        read_rand(16'h0005, 1, ok);
        check("R8 locked location unchanged", rbuf[0], model[5]);
    endtask

    task automatic t_abort_start;
        bit k;
        int polls;
        bus_start;
        send_byte(8'hA4, k);
        send_byte(8'h00, k);
        send_byte(8'h30, k);
        send_byte(8'hEE, k);
        bus_start;
        send_byte(8'hA5, k);
        check("R1 repeated START accepts new select", k, 1);
        recv_byte(1'b0, rbuf[0]);
        bus_stop;
        check("R11 current read after aborted write", rbuf[0], model[8'h31]);
        wait_ready(polls);
        check("R6 START abort starts no busy window", polls, 1);
        read_rand(16'h0030, 1, k);
        check("R6 START abort programs nothing", rbuf[0], model[8'h30]);
    endtask

    task automatic t_abort_midbyte;
        bit k;
        int polls;
        bus_start;
        send_byte(8'hA4, k);
        send_byte(8'h00, k);
        send_byte(8'h31, k);
        send_byte(8'h5A, k);
        send_bits(8'hFF, 3);
        bus_stop;
        wait_ready(polls);
        check("R6 mid-byte STOP starts no busy window", polls, 1);
        read_rand(16'h0031, 1, k);
        check("R6 mid-byte STOP programs nothing", rbuf[0], model[8'h31]);
    endtask

    task automatic t_mismatch;
        bit k;
        bus_start;
        send_byte(8'hA2, k);
        check("R2 foreign strap select not acknowledged", k, 0);
        send_byte(8'h00, k);
        check("R2 line stays released after miss", k, 0);
        bus_stop;
        straps = 2'b01;
        bus_start;
        send_byte(8'hA2, k);
        bus_stop;
        check("R2 select acknowledged after strap change", k, 1);
        straps = 2'b10;
    endtask

    task automatic t_upper_bits;
        bit ok;
        int polls;
        wbuf[0] = 8'h77;
        write_tx(16'hFFC9, 1, ok);
        model[8'h09] = 8'h77;
        wait_ready(polls);
        read_rand(16'h0009, 1, ok);
        check("R3 upper address bits ignored", rbuf[0], 8'h77);
    endtask

    task automatic t_rollover;
        bit ok;
        logic [7:0] b;
        read_rand(16'h003E, 4, ok);
        check("R10 read at 0x3E", rbuf[0], model[62]);
        check("R10 read at 0x3F", rbuf[1], model[63]);
        check("R10 rollover to 0x00", rbuf[2], model[0]);
        check("R10 read at 0x01", rbuf[3], model[1]);
        bus_start;
        send_byte(8'hA5, ok);
        recv_byte(1'b0, b);
        bus_stop;
        check("R11 current read continues at 0x02", b, model[2]);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_prefill;
        t_page_wrap;
        t_partial;
        t_lock;
        t_abort_start;
        t_abort_midbyte;
        t_mismatch;
        t_upper_bits;
        t_rollover;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule